// File: doc/BRIEF.md
# Serial EEPROM Pin Controller

This block sits between a three-wire serial EEPROM and the rest of a network controller. It owns two pads that are shared with LED outputs: the EEPROM clock pad and the EEPROM data-out pad. On each clock it decides who owns the pads. The LED sources can own them. An internal engine that reads the whole EEPROM can own them. Host software can own them by bit-banging a small register.

While reset is held, both pads are inputs. On the last rising clock edge before reset is released, the block samples the clock pad and stores the level as an EEPROM-present flag. A board with an EEPROM pulls that pad high; a board without one pulls it low. If no EEPROM was found, the pads stay in LED duty until the next reset.

An owner state machine has four states:
- HOLD: the state during reset.
- LED: the pads carry the LED signals.
- ENGINE: the engine drives the clock pad.
- HOST: the clock pad follows the host clock bit.

From any state, the next state is chosen in a fixed order after reset is released:
- LED when the present flag is 0.
- Otherwise ENGINE when the engine is busy.
- Otherwise HOST when the host ownership bit is set.
- Otherwise LED.

Top module: `eeprom_pin_ctrl`

## Requirements
- R1: While `rst` is high, both `sk_pad_oe` and `do_pad_oe` are 0.
- R2: After reset, the present flag (register bit 3) equals the level of `sk_pad_i` at the last rising `clk` edge on which `rst` was high: 1 for high, 0 for low.
- R3: The present flag cannot be changed by a register write. It keeps its value until the next reset, whatever `sk_pad_i` does afterwards.
- R4: When the present flag is 0, the pads stay in LED mode in every cycle after reset. `eng_busy` and the host bits have no effect.
- R5: When the flag is 1 and `eng_busy` is high at a clock edge, the following cycle is in ENGINE mode:
  - `sk_pad_oe`=1 and `sk_pad_o` follows `eng_sk`.
  - `do_pad_oe`=0 and `do_pad_o`=0.
- R6: When the flag is 1, `eng_busy` is low and the host ownership bit (bit 2) is 1 at an edge, the following cycle is in HOST mode:
  - `sk_pad_oe`=1 and `sk_pad_o` equals register bit 1.
  - `do_pad_oe`=0.
  - A write that takes effect at that edge counts.
- R7: The engine has priority: when `eng_busy` is high, the host bits do not affect the clock pad.
- R8: `reg_rdata` bit 0 always reflects the current level of `do_pad_i`.
- R9: In LED mode, both output enables are 1, `sk_pad_o`=`led_a` and `do_pad_o`=`led_b`.
- R10: Register bits 1 (host clock) and 2 (host ownership) are read/write, return the last value written, and reset to 0. Bits 0 and 3 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data: {present, own, host clock, data-out level} |
| eng_busy | input | 1 | Whole-device read engine is active |
| eng_sk | input | 1 | Engine's EEPROM clock |
| led_a | input | 1 | LED source for the clock pad |
| led_b | input | 1 | LED source for the data-out pad |
| sk_pad_i | input | 1 | Clock pad input level |
| sk_pad_o | output | 1 | Clock pad output value |
| sk_pad_oe | output | 1 | Clock pad output enable |
| do_pad_i | input | 1 | Data-out pad input level |
| do_pad_o | output | 1 | Data-out pad output value |
| do_pad_oe | output | 1 | Data-out pad output enable |

## Verification
The assertions check the following on every cycle:
- The pads are tri-stated during reset.
- The present flag is steady outside reset.
- The pads stay in LED mode when no EEPROM was detected.
- The engine and host modes are entered one edge after their request.
- Idle returns the pads to LED duty.

Only the bench scenarios can show some other behaviours:
- The flag captures the final reset-edge level rather than an earlier one.
- The flag survives pad changes after reset.
- The sweep over every combination of busy, ownership, clock bit and LED inputs gives the expected pad values under both detect results.

// File: rtl/eepin_pkg.sv
package eepin_pkg;
    localparam int unsigned REG_W   = 4;
    localparam int unsigned BIT_DO  = 0;
    localparam int unsigned BIT_SK  = 1;
    localparam int unsigned BIT_OWN = 2;
    localparam int unsigned BIT_PRS = 3;
    localparam int unsigned NPADS   = 2;
    localparam int unsigned PAD_SK  = 0;
    localparam int unsigned PAD_DO  = 1;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_LED    = 2'd1,
        ST_ENGINE = 2'd2,
        ST_HOST   = 2'd3
    } own_state_t;
endpackage

// File: rtl/eepin_detect.sv
module eepin_detect (
    input  logic clk,
    input  logic rst,
    input  logic sk_level,
    output logic present
);
    // Resampled on every reset edge; the last one wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            present <= sk_level;
        end
    end
endmodule

// File: rtl/eepin_owner_fsm.sv
module eepin_owner_fsm
    import eepin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic present,
    input  logic eng_busy,
    input  logic host_own,
    output logic hold,
    output logic eeprom_mode,
    output logic eng_sel
);
    own_state_t state_q, state_d;

    function automatic own_state_t pick(input logic prs, input logic busy, input logic own);
        if (!prs)      return ST_LED;
        else if (busy) return ST_ENGINE;
        else if (own)  return ST_HOST;
        else           return ST_LED;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   state_d = pick(present, eng_busy, host_own);
            ST_LED:    state_d = pick(present, eng_busy, host_own);
            ST_ENGINE: state_d = pick(present, eng_busy, host_own);
            ST_HOST:   state_d = pick(present, eng_busy, host_own);
            default:   state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        hold        = 1'b0;
        eeprom_mode = 1'b0;
        eng_sel     = 1'b0;
        unique case (state_q)
            ST_HOLD:   hold = 1'b1;
            ST_LED:    ;
            ST_ENGINE: begin eeprom_mode = 1'b1; eng_sel = 1'b1; end
            ST_HOST:   eeprom_mode = 1'b1;
            default:   hold = 1'b1;
        endcase
        if (rst) hold = 1'b1;
    end
endmodule

// File: rtl/eepin_pad_cell.sv
module eepin_pad_cell #(
    parameter bit EE_DRIVE = 1'b1
) (
    input  logic hold,
    input  logic eeprom_mode,
    input  logic led_val,
    input  logic ee_val,
    output logic pad_o,
    output logic pad_oe
);
    always_comb begin
        if (hold) begin
            pad_o  = 1'b0;
            pad_oe = 1'b0;
        end else if (eeprom_mode) begin
            pad_o  = EE_DRIVE ? ee_val : 1'b0;
            pad_oe = EE_DRIVE;
        end else begin
            pad_o  = led_val;
            pad_oe = 1'b1;
        end
    end
endmodule

// File: rtl/eeprom_pin_ctrl.sv
module eeprom_pin_ctrl
    import eepin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             eng_busy,
    input  logic             eng_sk,
    input  logic             led_a,
    input  logic             led_b,
    input  logic             sk_pad_i,
    output logic             sk_pad_o,
    output logic             sk_pad_oe,
    input  logic             do_pad_i,
    output logic             do_pad_o,
    output logic             do_pad_oe
);
    logic present;
    logic host_sk_q, host_own_q, own_eff;
    logic hold, eeprom_mode, eng_sel;
    logic [NPADS-1:0] led_v, ee_v, pad_o_v, pad_oe_v;
    logic unused_wbits;

    assign unused_wbits = ^{reg_wdata[BIT_DO], reg_wdata[BIT_PRS]};

    eepin_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .sk_level (sk_pad_i),
        .present  (present)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_sk_q  <= 1'b0;
            host_own_q <= 1'b0;
        end else if (reg_we) begin
            host_sk_q  <= reg_wdata[BIT_SK];
            host_own_q <= reg_wdata[BIT_OWN];
        end
    end

    assign own_eff = reg_we ? reg_wdata[BIT_OWN] : host_own_q;

    eepin_owner_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .present     (present),
        .eng_busy    (eng_busy),
        .host_own    (own_eff),
        .hold        (hold),
        .eeprom_mode (eeprom_mode),
        .eng_sel     (eng_sel)
    );

    assign led_v[PAD_SK] = led_a;
    assign led_v[PAD_DO] = led_b;
    assign ee_v[PAD_SK]  = eng_sel ? eng_sk : host_sk_q;
    assign ee_v[PAD_DO]  = 1'b0;

    for (genvar i = 0; i < NPADS; i++) begin : g_pad
        eepin_pad_cell #(.EE_DRIVE(i == PAD_SK)) u_cell (
            .hold        (hold),
            .eeprom_mode (eeprom_mode),
            .led_val     (led_v[i]),
            .ee_val      (ee_v[i]),
            .pad_o       (pad_o_v[i]),
            .pad_oe      (pad_oe_v[i])
        );
    end

    assign sk_pad_o  = pad_o_v[PAD_SK];
    assign sk_pad_oe = pad_oe_v[PAD_SK];
    assign do_pad_o  = pad_o_v[PAD_DO];
    assign do_pad_oe = pad_oe_v[PAD_DO];

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[BIT_DO]  = do_pad_i;
        reg_rdata[BIT_SK]  = host_sk_q;
        reg_rdata[BIT_OWN] = host_own_q;
        reg_rdata[BIT_PRS] = present;
    end
endmodule

// File: rtl/eepin_checker.sv
module eepin_checker (
    input logic clk,
    input logic rst,
    input logic reg_we,
    input logic wr_sk,
    input logic wr_own,
    input logic present,
    input logic own_q,
    input logic eng_busy,
    input logic eng_sk,
    input logic led_a,
    input logic led_b,
    input logic sk_pad_o,
    input logic sk_pad_oe,
    input logic do_pad_o,
    input logic do_pad_oe
);
    AST_PADS_IN_RESET: assert property (@(posedge clk)
        rst |-> (!sk_pad_oe && !do_pad_oe)); // R1

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(present)); // R3

    AST_ABSENT_LED: assert property (@(posedge clk) disable iff (rst)
        !present |=> (sk_pad_oe && do_pad_oe)); // R4

    AST_ENGINE_OWNS: assert property (@(posedge clk) disable iff (rst)
        (present && eng_busy) |=> (sk_pad_oe && !do_pad_oe && sk_pad_o == eng_sk)); // R5

    AST_HOST_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (present && !eng_busy && reg_we && wr_own)
            |=> (sk_pad_oe && !do_pad_oe && sk_pad_o == $past(wr_sk))); // R6

    AST_LED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!eng_busy && !reg_we && !own_q)
            |=> (sk_pad_oe && do_pad_oe && sk_pad_o == led_a && do_pad_o == led_b)); // R9
endmodule

bind eeprom_pin_ctrl eepin_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .wr_sk     (reg_wdata[1]),
    .wr_own    (reg_wdata[2]),
    .present   (reg_rdata[3]),
    .own_q     (reg_rdata[2]),
    .eng_busy  (eng_busy),
    .eng_sk    (eng_sk),
    .led_a     (led_a),
    .led_b     (led_b),
    .sk_pad_o  (sk_pad_o),
    .sk_pad_oe (sk_pad_oe),
    .do_pad_o  (do_pad_o),
    .do_pad_oe (do_pad_oe)
);

// File: tb/sim_eeprom_pin_ctrl.sv
`timescale 1ns/1ps
module sim_eeprom_pin_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata;
    logic eng_busy = 1'b0, eng_sk = 1'b0, led_a = 1'b0, led_b = 1'b0;
    logic sk_pad_i = 1'b0, do_pad_i = 1'b0;
    logic sk_pad_o, sk_pad_oe, do_pad_o, do_pad_oe;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    eeprom_pin_ctrl u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .eng_busy(eng_busy), .eng_sk(eng_sk),
        .led_a(led_a), .led_b(led_b), .sk_pad_i(sk_pad_i),
        .sk_pad_o(sk_pad_o), .sk_pad_oe(sk_pad_oe), .do_pad_i(do_pad_i),
        .do_pad_o(do_pad_o), .do_pad_oe(do_pad_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pads(input string req, input logic so, input logic soe,
                        input logic dout, input logic doe);
        check(req, {4'h0, sk_pad_o, sk_pad_oe, do_pad_o, do_pad_oe},
              {4'h0, so, soe, dout, doe});
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst = 1'b1; reg_we = 1'b0; eng_busy = 1'b0;
        sk_pad_i = ~lvl;
        #1 check("R1", {6'h0, sk_pad_oe, do_pad_oe}, 8'h00);
        repeat (2) @(negedge clk);
        sk_pad_i = lvl;
        @(negedge clk);
        rst = 1'b0;
        sk_pad_i = ~lvl;
        @(negedge clk);
        check("R2", {7'h0, reg_rdata[3]}, {7'h0, lvl});
        check("R10", {6'h0, reg_rdata[2:1]}, 8'h00);
    endtask

    // One sweep point: busy/own/clock bit applied at an edge, pads checked after it.
    task automatic point(input logic prs, input logic [5:0] v);
        logic b, o, c, e, la, lb;
        {b, o, c, e, la, lb} = v;
        @(negedge clk);
        eng_busy = b; reg_we = 1'b1; reg_wdata = {~prs, o, c, 1'b1};
        eng_sk = e; led_a = la; led_b = lb; do_pad_i = c ^ e;
        @(posedge clk);
        #1 reg_we = 1'b0;
        if (!prs || (!b && !o)) pads(prs ? "R9" : "R4", la, 1'b1, lb, 1'b1);
        else if (b) pads(o ? "R7" : "R5", e, 1'b1, 1'b0, 1'b0);
        else pads("R6", c, 1'b1, 1'b0, 1'b0);
        check("R10", {6'h0, reg_rdata[2:1]}, {6'h0, o, c});
        check("R3", {7'h0, reg_rdata[3]}, {7'h0, prs});
        check("R8", {7'h0, reg_rdata[0]}, {7'h0, c ^ e});
    endtask

    initial begin
        #400000;
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int r = 0; r < 2; r++) begin
            logic prs;
            prs = (r == 0);
            do_reset(prs);
            for (int k = 0; k < 64; k++) point(prs, k[5:0]);
            // Engine ends with ownership set: HOST next (R6), then cleared: LED (R9)
            @(negedge clk);
            eng_busy = 1'b1; reg_we = 1'b1; reg_wdata = 4'b0110;
            @(negedge clk);
            reg_we = 1'b0; eng_busy = 1'b0;
            @(negedge clk);
            if (prs) pads("R6", 1'b1, 1'b1, 1'b0, 1'b0);
            else     pads("R4", led_a, 1'b1, led_b, 1'b1);
            reg_we = 1'b1; reg_wdata = 4'b0000;
            @(negedge clk);
            reg_we = 1'b0;
            pads("R9", led_a, 1'b1, led_b, 1'b1);
            sk_pad_i = ~prs;
            repeat (3) @(negedge clk);
            check("R3", {7'h0, reg_rdata[3]}, {7'h0, prs});
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule